// File: doc/BRIEF.md
# Test Access Port Slave with Instruction Decode

This block is the serial test port of a chip. A slow test clock and a mode-select line steer a sixteen-state controller. A serial data line carries opcodes into a 10-bit instruction register and carries data through whichever data register the active instruction selects. The serial output changes only on falling clock edges, and it comes with an enable that is high only while a register is being shifted.

The data registers inside the block are a one-bit pass-through stage, a 32-bit identification value and a 32-bit user signature. Both 32-bit values share one shift register. Cell-level boundary logic lives outside the block. The block drives capture, shift and update strobes for it, plus a drive-mode flag, and it takes that chain's serial output back in. The reset input is synchronous and active high, and it is sampled on rising test-clock edges.

Top module: `scan_tap`

## Requirements
- R1: The controller has sixteen states and moves on every rising `test_clk` edge as `mode_sel` dictates. A data scan may pass through the pause states and return to shifting without losing or repeating a bit.
- R2: The controller goes to its reset state on a rising edge with `test_rst` high, and after five consecutive rising edges with `mode_sel` high from any state. Either way, the identification instruction becomes active again.
- R3: After reset, the active instruction is the identification instruction (or the pass-through instruction when `HAS_ID` is 0). A data scan with no instruction load then returns `ID_VALUE`.
- R4: On entering instruction capture, the instruction shift register loads 0000000001. The first two bits shifted out are therefore 1 and then 0, followed by eight zeros.
- R5: Opcodes are 10 bits and are shifted in LSB first. 0000000000 selects external drive, 0001010101 selects sample/preload, 1111111111 selects pass-through, 0000000110 selects identification and 0000000111 selects user signature. Any other code acts as pass-through. The active instruction changes only on the falling edge while in the instruction-update state.
- R6: Pass-through captures 0. A bit taken from `ser_in` on a rising edge appears on `ser_out` at the falling edge of the same clock pulse, so an n-bit scan returns 0 followed by the first n-1 input bits.
- R7: The identification and user-signature instructions load `ID_VALUE` or `USER_VALUE` in data capture and shift it out LSB first.
- R8: `ser_out` and `ser_oe` change only on falling edges. `ser_oe` rises at the first falling edge inside a shift state, falls at the first falling edge after leaving it, and is low in every other state.
- R9: `bnd_capture` and `bnd_shift` are high in data capture and data shift only for sample/preload and external drive, and `chain_in` then feeds `ser_out`. `bnd_update` is a one-cycle pulse that starts at the falling edge in the data-update state, for those two instructions only.
- R10: `bnd_drive` is high only while external drive is the active instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock |
| test_rst | input | 1 | Synchronous active-high reset of the controller |
| mode_sel | input | 1 | Controller steering line, sampled on rising edge |
| ser_in | input | 1 | Serial data in, sampled on rising edge |
| chain_in | input | 1 | Serial output of the external boundary chain |
| ser_out | output | 1 | Serial data out, updated on falling edge |
| ser_oe | output | 1 | Output enable for `ser_out` |
| bnd_capture | output | 1 | Boundary chain capture enable |
| bnd_shift | output | 1 | Boundary chain shift enable |
| bnd_update | output | 1 | Boundary chain update pulse from the falling edge |
| bnd_drive | output | 1 | Boundary cells drive the pins (external drive active) |

## Verification
The bench loads the instruction register many times. Each load compares the 1-then-0 capture pattern, which catches a design that leaves the old opcode in place or loads the pattern in reverse. Pass-through and unknown-opcode scans show whether there is exactly one bit of delay and a leading 0; an extra stage or a missing capture shifts the whole stream. A data scan broken by a pause must resume at the right bit. The bench also checks that the drive flag changes at the falling edge of the update state and not at the rising edge. It checks that five high mode bits restore the identification instruction and that the update pulse appears only for boundary instructions. Each of these faults would otherwise go unseen at a board tester.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int OPC_W = 10;

    localparam logic [OPC_W-1:0] OPC_EXTEST  = 10'b0000000000;
    localparam logic [OPC_W-1:0] OPC_SAMPLE  = 10'b0001010101;
    localparam logic [OPC_W-1:0] OPC_BYPASS  = 10'b1111111111;
    localparam logic [OPC_W-1:0] OPC_IDENT   = 10'b0000000110;
    localparam logic [OPC_W-1:0] OPC_USER    = 10'b0000000111;
    localparam logic [OPC_W-1:0] IR_CAP_PAT  = 10'b0000000001;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
    } tap_state_t;

    typedef enum logic [2:0] {
        INS_EXTEST, INS_SAMPLE, INS_BYPASS, INS_IDENT, INS_USER
    } instr_t;

    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        case (s)
            ST_RESET:    return m ? ST_RESET   : ST_IDLE;
            ST_IDLE:     return m ? ST_DR_SEL  : ST_IDLE;
            ST_DR_SEL:   return m ? ST_IR_SEL  : ST_DR_CAP;
            ST_DR_CAP:   return m ? ST_DR_EX1  : ST_DR_SHIFT;
            ST_DR_SHIFT: return m ? ST_DR_EX1  : ST_DR_SHIFT;
            ST_DR_EX1:   return m ? ST_DR_UPD  : ST_DR_PAUSE;
            ST_DR_PAUSE: return m ? ST_DR_EX2  : ST_DR_PAUSE;
            ST_DR_EX2:   return m ? ST_DR_UPD  : ST_DR_SHIFT;
            ST_DR_UPD:   return m ? ST_DR_SEL  : ST_IDLE;
            ST_IR_SEL:   return m ? ST_RESET   : ST_IR_CAP;
            ST_IR_CAP:   return m ? ST_IR_EX1  : ST_IR_SHIFT;
            ST_IR_SHIFT: return m ? ST_IR_EX1  : ST_IR_SHIFT;
            ST_IR_EX1:   return m ? ST_IR_UPD  : ST_IR_PAUSE;
            ST_IR_PAUSE: return m ? ST_IR_EX2  : ST_IR_PAUSE;
            ST_IR_EX2:   return m ? ST_IR_UPD  : ST_IR_SHIFT;
            ST_IR_UPD:   return m ? ST_DR_SEL  : ST_IDLE;
            default:     return ST_RESET;
        endcase
    endfunction

    function automatic instr_t decode_opc(input logic [OPC_W-1:0] op, input bit has_id);
        if (op == OPC_EXTEST)              return INS_EXTEST;
        if (op == OPC_SAMPLE)              return INS_SAMPLE;
        if (op == OPC_IDENT && has_id)     return INS_IDENT;
        if (op == OPC_USER && has_id)      return INS_USER;
        return INS_BYPASS;
    endfunction

    function automatic logic is_boundary(input instr_t i);
        return (i == INS_EXTEST) || (i == INS_SAMPLE);
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_sel,
    output tap_state_t state
);

    localparam int HIGH_RUN = 5;
    localparam int CNT_W    = $clog2(HIGH_RUN + 1);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, mode_sel);
    end

    // consecutive high-mode counter, used only by the check below
    logic [CNT_W-1:0] high_run;
    always_ff @(posedge clk) begin
        if (rst || !mode_sel)                     high_run <= '0;
        else if (high_run != CNT_W'(HIGH_RUN))    high_run <= high_run + 1'b1;
    end

    AST_FIVE_HIGH_RESETS: assert property (@(posedge clk) disable iff (rst)
        (high_run == CNT_W'(HIGH_RUN)) |-> (state == ST_RESET)); // R2

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
#(
    parameter bit HAS_ID = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  tap_state_t state,
    input  logic       ser_in,
    output logic       ir_lsb,
    output instr_t     active
);

    localparam instr_t RESET_INS = HAS_ID ? INS_IDENT : INS_BYPASS;

    logic [OPC_W-1:0] ir_sr;

    always_ff @(posedge clk) begin
        if (rst)                         ir_sr <= IR_CAP_PAT;
        else if (state == ST_IR_CAP)     ir_sr <= IR_CAP_PAT;
        else if (state == ST_IR_SHIFT)   ir_sr <= {ser_in, ir_sr[OPC_W-1:1]};
    end

    // active instruction moves only on the falling edge
    always_ff @(negedge clk) begin
        if (rst || state == ST_RESET)    active <= RESET_INS;
        else if (state == ST_IR_UPD)     active <= decode_opc(ir_sr, HAS_ID);
    end

    assign ir_lsb = ir_sr[0];

    AST_IR_CAPTURE_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IR_CAP) |=> (ir_sr[1:0] == 2'b01)); // R4

    AST_ACTIVE_ONLY_IN_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !(state == ST_IR_UPD || state == ST_RESET) |-> $stable(active)); // R5

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int          ID_W       = 32,
    parameter logic [31:0] ID_VALUE   = 32'h0ACE_5093,
    parameter logic [31:0] USER_VALUE = 32'h5EED_1234
) (
    input  logic       clk,
    input  logic       rst,
    input  tap_state_t state,
    input  instr_t     instr,
    input  logic       ser_in,
    output logic       byp_bit,
    output logic       id_lsb
);

    localparam logic [ID_W-1:0] ID_LOAD   = ID_W'(ID_VALUE);
    localparam logic [ID_W-1:0] USER_LOAD = ID_W'(USER_VALUE);

    logic [ID_W-1:0] id_sr;
    logic            id_sel;

    assign id_sel = (instr == INS_IDENT) || (instr == INS_USER);

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_bit <= 1'b0;
        end else if (instr == INS_BYPASS) begin
            if (state == ST_DR_CAP)        byp_bit <= 1'b0;
            else if (state == ST_DR_SHIFT) byp_bit <= ser_in;
        end
    end

    // one shift register serves both 32-bit values
    always_ff @(posedge clk) begin
        if (rst) begin
            id_sr <= ID_LOAD;
        end else if (id_sel) begin
            if (state == ST_DR_CAP)        id_sr <= (instr == INS_USER) ? USER_LOAD : ID_LOAD;
            else if (state == ST_DR_SHIFT) id_sr <= {ser_in, id_sr[ID_W-1:1]};
        end
    end

    assign id_lsb = id_sr[0];

    AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DR_CAP && instr == INS_BYPASS) |=> (byp_bit == 1'b0)); // R6

    AST_ID_LOADED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DR_CAP && instr == INS_IDENT) |=> (id_sr == ID_LOAD)); // R7

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter bit          HAS_ID     = 1'b1,
    parameter int          ID_W       = 32,
    parameter logic [31:0] ID_VALUE   = 32'h0ACE_5093,
    parameter logic [31:0] USER_VALUE = 32'h5EED_1234
) (
    input  logic test_clk,
    input  logic test_rst,
    input  logic mode_sel,
    input  logic ser_in,
    input  logic chain_in,
    output logic ser_out,
    output logic ser_oe,
    output logic bnd_capture,
    output logic bnd_shift,
    output logic bnd_update,
    output logic bnd_drive
);

    tap_state_t state;
    instr_t     active;
    logic       ir_lsb, byp_bit, id_lsb;
    logic       in_shift, bnd_sel, next_bit;

    scan_tap_fsm u_fsm (
        .clk(test_clk), .rst(test_rst), .mode_sel(mode_sel), .state(state)
    );

    scan_tap_ir #(.HAS_ID(HAS_ID)) u_ir (
        .clk(test_clk), .rst(test_rst), .state(state), .ser_in(ser_in),
        .ir_lsb(ir_lsb), .active(active)
    );

    scan_tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE), .USER_VALUE(USER_VALUE)) u_dr (
        .clk(test_clk), .rst(test_rst), .state(state), .instr(active),
        .ser_in(ser_in), .byp_bit(byp_bit), .id_lsb(id_lsb)
    );

    assign in_shift = (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
    assign bnd_sel  = is_boundary(active);

    always_comb begin
        if (state == ST_IR_SHIFT) begin
            next_bit = ir_lsb;
        end else begin
            case (active)
                INS_IDENT, INS_USER:    next_bit = id_lsb;
                INS_EXTEST, INS_SAMPLE: next_bit = chain_in;
                default:                next_bit = byp_bit;
            endcase
        end
    end

    always_ff @(negedge test_clk) begin
        if (test_rst) begin
            ser_out    <= 1'b0;
            ser_oe     <= 1'b0;
            bnd_update <= 1'b0;
        end else begin
            ser_oe     <= in_shift;
            bnd_update <= (state == ST_DR_UPD) && bnd_sel;
            if (in_shift) ser_out <= next_bit;
        end
    end

    assign bnd_capture = (state == ST_DR_CAP)   && bnd_sel;
    assign bnd_shift   = (state == ST_DR_SHIFT) && bnd_sel;
    assign bnd_drive   = (active == INS_EXTEST);

    AST_OE_ONLY_IN_SHIFT: assert property (@(posedge test_clk) disable iff (test_rst)
        ser_oe |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT)); // R8

    AST_UPDATE_IN_DR_UPDATE: assert property (@(posedge test_clk) disable iff (test_rst)
        bnd_update |-> (state == ST_DR_UPD)); // R9

    AST_STROBES_EXCLUSIVE: assert property (@(posedge test_clk) disable iff (test_rst)
        $onehot0({bnd_capture, bnd_shift, bnd_update})); // R9

endmodule

// File: tb/scan_tap_tb_top.sv
`timescale 1ns/1ps
module scan_tap_tb_top;

    localparam logic [31:0] ID_V   = 32'h0ACE_5093;
    localparam logic [31:0] USER_V = 32'h5EED_1234;
    localparam logic [9:0]  C_EXT  = 10'b0000000000;
    localparam logic [9:0]  C_SMP  = 10'b0001010101;
    localparam logic [9:0]  C_BYP  = 10'b1111111111;
    localparam logic [9:0]  C_IDC  = 10'b0000000110;
    localparam logic [9:0]  C_USR  = 10'b0000000111;

    logic test_clk = 1'b0;
    logic test_rst = 1'b1;
    logic mode_sel = 1'b1;
    logic ser_in   = 1'b0;
    logic chain_in;
    logic ser_out, ser_oe, bnd_capture, bnd_shift, bnd_update, bnd_drive;

    int checks = 0, failures = 0, upd_cnt = 0, sh_cnt = 0;
    bit done = 1'b0;
    logic mode_pre, mode_post;
    logic exp_q[$];
    string tag_q[$];
    logic [3:0] chain_model;

    always #4 test_clk = ~test_clk;

    scan_tap dut_i (
        .test_clk(test_clk), .test_rst(test_rst), .mode_sel(mode_sel), .ser_in(ser_in),
        .chain_in(chain_in), .ser_out(ser_out), .ser_oe(ser_oe),
        .bnd_capture(bnd_capture), .bnd_shift(bnd_shift), .bnd_update(bnd_update),
        .bnd_drive(bnd_drive)
    );

    // external 4-cell boundary chain model
    always @(posedge test_clk) begin
        if (bnd_capture)    chain_model <= 4'b1010;
        else if (bnd_shift) chain_model <= {ser_in, chain_model[3:1]};
    end
    assign chain_in = chain_model[0];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops one expected bit per enabled falling edge
    always begin
        @(negedge test_clk);
        #2;
        if (!test_rst) begin
            if (ser_oe) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 output enabled with no bit expected", 64'(ser_oe), 64'd0);
                end else begin
                    logic e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(ser_out === e, t, 64'(ser_out), 64'(e));
                end
            end
            if (bnd_update) upd_cnt++;
            if (bnd_shift)  sh_cnt++;
        end
    end

    task automatic push_bits(input int n, input logic [63:0] bits, input string t);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(bits[i]);
            tag_q.push_back(t);
        end
    endtask

    task automatic step(input logic m, input logic d);
        @(negedge test_clk);
        #1;
        mode_sel = m;
        ser_in   = d;
        @(posedge test_clk);
        #1;
    endtask

    // from idle: load an opcode and return to idle
    task automatic load_ir(input logic [9:0] opc);
        step(1, 0);
        step(1, 0);
        step(0, 0);
        push_bits(10, 64'(10'b0000000001), "R4 instruction capture pattern");
        step(0, 0);
        for (int i = 0; i < 10; i++) step(i == 9, opc[i]);
        step(1, 0);                       // now in instruction update
        mode_pre = bnd_drive;
        @(negedge test_clk);
        #1;
        mode_post = bnd_drive;
        mode_sel = 0;
        @(posedge test_clk);
        #1;
    endtask

    // from idle: scan n data bits and return to idle
    task automatic scan_dr(input int n, input logic [63:0] data, input logic [63:0] exp, input string t);
        step(1, 0);
        step(0, 0);
        push_bits(n, exp, t);
        step(0, 0);
        chk(ser_oe == 1'b0, "R8 enable before first falling edge", 64'(ser_oe), 64'd0);
        for (int i = 0; i < n; i++) step(i == n - 1, data[i]);
        chk(ser_oe == 1'b1, "R8 enable held until falling edge", 64'(ser_oe), 64'd1);
        @(negedge test_clk);
        #1;
        chk(ser_oe == 1'b0, "R8 enable drops after leaving shift", 64'(ser_oe), 64'd0);
        mode_sel = 1;
        @(posedge test_clk);
        #1;
        step(0, 0);
    endtask

    initial begin
        int u0, s0;
        repeat (3) @(posedge test_clk);
        #1;
        chk(ser_oe == 1'b0, "R8 reset enable", 64'(ser_oe), 64'd0);
        chk(bnd_drive == 1'b0, "R10 reset drive flag", 64'(bnd_drive), 64'd0);
        chk(bnd_capture == 1'b0 && bnd_shift == 1'b0, "R9 reset strobes",
            64'({bnd_capture, bnd_shift}), 64'd0);
        test_rst = 1'b0;
        step(0, 0);

        // R3 identification after reset, no boundary strobes
        u0 = upd_cnt; s0 = sh_cnt;
        scan_dr(32, 64'hFFFF_0000_1234_5678, 64'(ID_V), "R3 identification after reset");
        chk(upd_cnt == u0 && sh_cnt == s0, "R9 no strobes for identification",
            64'(upd_cnt - u0 + sh_cnt - s0), 64'd0);

        // R7 user signature
        load_ir(C_USR);
        scan_dr(32, 64'd0, 64'(USER_V), "R7 user signature");

        // R6 pass-through
        load_ir(C_BYP);
        scan_dr(8, 64'hB5, 64'({7'h35, 1'b0}), "R6 pass-through delay");

        // R5 unknown opcode behaves as pass-through
        load_ir(10'b1010101010);
        scan_dr(8, 64'h3C, 64'({7'h3C, 1'b0}), "R5 unknown opcode");

        // R9 sample/preload uses external chain
        load_ir(C_SMP);
        chk(mode_post == 1'b0, "R10 drive flag off for sample", 64'(mode_post), 64'd0);
        u0 = upd_cnt; s0 = sh_cnt;
        scan_dr(6, 64'b110010, 64'({1'b1, 1'b0, 4'b1010}), "R9 chain data on output");
        chk(upd_cnt == u0 + 1, "R9 one update pulse", 64'(upd_cnt - u0), 64'd1);
        chk(sh_cnt == s0 + 6, "R9 shift strobe cycles", 64'(sh_cnt - s0), 64'd6);

        // R5/R10 external drive, flag moves at the falling edge
        load_ir(C_EXT);
        chk(mode_pre == 1'b0, "R5 instruction unchanged before falling edge", 64'(mode_pre), 64'd0);
        chk(mode_post == 1'b1, "R10 drive flag for external drive", 64'(mode_post), 64'd1);
        scan_dr(4, 64'b0110, 64'b1010, "R9 chain data under drive");
        chk(bnd_drive == 1'b1, "R10 drive flag held", 64'(bnd_drive), 64'd1);

        // R2 five high mode bits
        for (int i = 0; i < 5; i++) step(1, 0);
        @(negedge test_clk);
        #1;
        chk(bnd_drive == 1'b0, "R2 five high bits clear drive", 64'(bnd_drive), 64'd0);
        step(0, 0);
        scan_dr(32, 64'd0, 64'(ID_V), "R2 identification after five high bits");

        // R2 synchronous reset mid-use
        load_ir(C_BYP);
        test_rst = 1'b1;
        step(0, 0);
        step(0, 0);
        test_rst = 1'b0;
        step(0, 0);
        scan_dr(32, 64'd0, 64'(ID_V), "R2 identification after reset input");

        // R1 scan broken by a pause
        load_ir(C_IDC);
        step(1, 0);
        step(0, 0);
        push_bits(32, 64'(ID_V), "R1 scan across pause");
        step(0, 0);
        for (int i = 0; i < 16; i++) step(i == 15, 1'b0);
        step(0, 0);
        step(0, 0);
        chk(ser_oe == 1'b0, "R1 enable low in pause", 64'(ser_oe), 64'd0);
        step(1, 0);
        step(0, 0);
        for (int i = 0; i < 16; i++) step(i == 15, 1'b0);
        step(1, 0);
        step(0, 0);

        chk(exp_q.size() == 0, "R8 all expected bits seen", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule